// File: doc/BRIEF.md
# Voice-Gated Recognizer Supervisor

This block is the always-on controller between a speech detector that never sleeps and a speech recognizer that sits behind a power switch. Once per audio frame the detector reports whether the frame holds speech. The supervisor turns that decision into a power-enable and a reset for the recognizer. A speech frame wakes the recognizer automatically. It stays in reset while the input is judged to be non-speech.

Wake-up and shut-down follow a fixed order. On wake-up, power is enabled first and reset is released only after a programmable settle time. On shut-down, a programmable run of consecutive non-speech frames must pass first; then reset is asserted, and power is removed one cycle later. Incoming audio samples are written into a circular buffer at all times. When the recognizer wakes, the buffer keeps only a fixed pre-roll of the newest samples for it. The recognizer then pulls these samples one request at a time, so it also hears the speech onset that arrived before it was powered.

Top module: `vgate_supervisor`

## Requirements
- R1: After reset, pwrEn is 0, recReset is 1, respValid is 0 and overflow is 0.
- R2: When the recognizer is off, a frame with frameValid=1 and frameSpeech=1 makes pwrEn 1 on the next cycle, while recReset stays 1.
- R3: recReset falls exactly settleCycles+1 cycles after pwrEn rises.
- R4: While the recognizer runs, fewer than hangFrames consecutive non-speech frames keep it running, and a speech frame restarts the run count. The hangFrames-th consecutive non-speech frame makes recReset 1 on the next cycle, and pwrEn falls one cycle after that.
- R5: pwrEn is never 0 while recReset is 0. Power is enabled before reset is released, and reset is asserted before power is removed.
- R6: The buffer holds DEPTH=16 samples and keeps the newest ones while the recognizer is off. On wake-up it keeps min(stored, PREROLL=6) of the newest samples for reading.
- R7: A request (reqValid=1) made while the recognizer runs and the buffer holds data gives respValid=1 on the next cycle. respData is then the oldest unread sample, in arrival order. A request while the buffer is empty, or while the recognizer is off or settling, gives no response.
- R8: A sample written into a full buffer while the recognizer is powered, with no read in the same cycle, drops the oldest sample and sets overflow. overflow stays set until the next wake-up clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| settleCycles | input | 8 | Extra cycles between power-enable and reset release |
| hangFrames | input | 6 | Consecutive non-speech frames needed to shut down |
| frameValid | input | 1 | Detector decision strobe, one per frame |
| frameSpeech | input | 1 | 1 = frame holds speech |
| sampleValid | input | 1 | Audio sample strobe |
| sampleData | input | 16 | Audio sample |
| pwrEn | output | 1 | Recognizer power enable |
| recReset | output | 1 | Recognizer reset, active high |
| reqValid | input | 1 | Recognizer sample request |
| respValid | output | 1 | Response strobe, one cycle after a served request |
| respData | output | 16 | Returned sample |
| overflow | output | 1 | Sticky flag: unread audio was lost |

## Verification
The power sequence is swept over every pairing of settle counts 0 to 4 and hang counts 1 to 4. Each sweep measures the exact release cycle, and an interrupted silence run tells apart a counter that restarts on speech from one that only accumulates. The pre-roll is tried with 0 to 12 samples and with 20 samples stored before wake-up. These cases separate clamping to the pre-roll from saturation at buffer depth and from reading stale or wrongly ordered data. A long burst without reads tells dropping the oldest sample apart from dropping the newest, and shows when the sticky flag is cleared.

// File: rtl/vgate_pkg.sv
package vgate_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2,
    ST_SHUT   = 2'd3
  } gateState_t;

  // strobes from control to the ring datapath
  typedef struct packed {
    logic wake;    // clamp unread level to the pre-roll, clear overflow
    logic armed;   // recognizer powered: losses count as overflow
    logic readOk;  // recognizer out of reset: requests may be served
  } ringCtl_t;
endpackage

// File: rtl/vgate_ctrl.sv
module vgate_ctrl
  import vgate_pkg::*;
#(
  parameter int CW = 8,
  parameter int HW = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] settleCycles,
  input  logic [HW-1:0] hangFrames,
  input  logic          frameValid,
  input  logic          frameSpeech,
  output logic          pwrEn,
  output logic          recReset,
  output ringCtl_t      ctl
);
  gateState_t    state;
  logic [CW-1:0] settleCnt;
  logic [HW-1:0] quietCnt;
  logic [HW:0]   quietNext;

  assign quietNext = {1'b0, quietCnt} + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      settleCnt <= '0;
      quietCnt  <= '0;
    end else begin
      case (state)
        ST_OFF: begin
          if (frameValid && frameSpeech) begin
            state     <= ST_SETTLE;
            settleCnt <= '0;
          end
        end
        ST_SETTLE: begin
          if (settleCnt == settleCycles) begin
            state    <= ST_RUN;
            quietCnt <= '0;
          end else begin
            settleCnt <= settleCnt + 1'b1;
          end
        end
        ST_RUN: begin
          if (frameValid) begin
            if (frameSpeech) begin
              quietCnt <= '0;
            end else if (quietNext >= {1'b0, hangFrames}) begin
              state    <= ST_SHUT;
              quietCnt <= '0;
            end else begin
              quietCnt <= quietNext[HW-1:0];
            end
          end
        end
        default: state <= ST_OFF;  // ST_SHUT: reset already high, drop power
      endcase
    end
  end

  assign pwrEn      = (state != ST_OFF);
  assign recReset   = (state != ST_RUN);
  assign ctl.wake   = (state == ST_OFF) && frameValid && frameSpeech;
  assign ctl.armed  = (state != ST_OFF);
  assign ctl.readOk = (state == ST_RUN);
endmodule

// File: rtl/vgate_ring.sv
module vgate_ring
  import vgate_pkg::*;
#(
  parameter int SW      = 16,
  parameter int DEPTH   = 16,
  parameter int PREROLL = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  ringCtl_t      ctl,
  input  logic          sampleValid,
  input  logic [SW-1:0] sampleData,
  input  logic          reqValid,
  output logic          respValid,
  output logic [SW-1:0] respData,
  output logic          overflow
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);
  localparam logic [LW-1:0] PRE_LVL  = LW'(PREROLL);

  logic [SW-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdIdx;
  logic [LW-1:0] level;
  logic [LW-1:0] baseLevel;
  logic [LW-1:0] nextLevel;
  logic          doRead;
  logic          isFull;
  logic          lossNow;

  // oldest unread entry sits `level` slots behind the write pointer
  assign rdIdx     = wrPtr - level[AW-1:0];
  assign doRead    = reqValid && ctl.readOk && (level != '0);
  assign baseLevel = (ctl.wake && (level > PRE_LVL)) ? PRE_LVL : level;
  assign isFull    = (baseLevel == FULL_LVL);
  assign lossNow   = sampleValid && isFull && !doRead && ctl.armed;

  always_comb begin
    nextLevel = baseLevel;
    if (sampleValid && !doRead && !isFull) nextLevel = baseLevel + 1'b1;
    else if (doRead && !sampleValid)       nextLevel = baseLevel - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (sampleValid) mem[wrPtr] <= sampleData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      level     <= '0;
      overflow  <= 1'b0;
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      level     <= nextLevel;
      respValid <= doRead;
      if (sampleValid) wrPtr <= wrPtr + 1'b1;
      if (doRead) respData <= mem[rdIdx];
      if (ctl.wake)     overflow <= 1'b0;
      else if (lossNow) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/vgate_supervisor.sv
module vgate_supervisor
  import vgate_pkg::*;
#(
  parameter int SW      = 16,
  parameter int DEPTH   = 16,
  parameter int PREROLL = 6,
  parameter int CW      = 8,
  parameter int HW      = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [CW-1:0] settleCycles,
  input  logic [HW-1:0] hangFrames,
  input  logic          frameValid,
  input  logic          frameSpeech,
  input  logic          sampleValid,
  input  logic [SW-1:0] sampleData,
  output logic          pwrEn,
  output logic          recReset,
  input  logic          reqValid,
  output logic          respValid,
  output logic [SW-1:0] respData,
  output logic          overflow
);
  ringCtl_t ctl;

  vgate_ctrl #(.CW(CW), .HW(HW)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .settleCycles (settleCycles),
    .hangFrames   (hangFrames),
    .frameValid   (frameValid),
    .frameSpeech  (frameSpeech),
    .pwrEn        (pwrEn),
    .recReset     (recReset),
    .ctl          (ctl)
  );

  vgate_ring #(.SW(SW), .DEPTH(DEPTH), .PREROLL(PREROLL)) u_ring (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .sampleValid (sampleValid),
    .sampleData  (sampleData),
    .reqValid    (reqValid),
    .respValid   (respValid),
    .respData    (respData),
    .overflow    (overflow)
  );
endmodule

// File: rtl/vgate_checker.sv
module vgate_checker (
  input logic clk,
  input logic rstN,
  input logic frameValid,
  input logic frameSpeech,
  input logic pwrEn,
  input logic recReset,
  input logic reqValid,
  input logic respValid,
  input logic overflow
);
  assert_never_unpowered_run_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(!pwrEn && !recReset));

  assert_power_before_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(recReset) |-> $past(pwrEn));

  assert_reset_before_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pwrEn) |-> $past(recReset));

  assert_speech_wakes_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!pwrEn && frameValid && frameSpeech) |=> (pwrEn && recReset));

  assert_resp_follows_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($past(reqValid) && !$past(recReset)));

  assert_overflow_clears_on_wake_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(overflow) |-> $past(!pwrEn && frameValid && frameSpeech));

  assert_overflow_needs_power_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(pwrEn));
endmodule

bind vgate_supervisor vgate_checker u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .frameValid  (frameValid),
  .frameSpeech (frameSpeech),
  .pwrEn       (pwrEn),
  .recReset    (recReset),
  .reqValid    (reqValid),
  .respValid   (respValid),
  .overflow    (overflow)
);

// File: tb/vgate_supervisor_bench.sv
module vgate_supervisor_bench;
  localparam int SW = 16, DEPTH = 16, PREROLL = 6, CW = 8, HW = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [CW-1:0] settleCycles = '0;
  logic [HW-1:0] hangFrames = 6'd2;
  logic          frameValid = 1'b0, frameSpeech = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic          reqValid = 1'b0;
  logic          pwrEn, recReset, respValid, overflow;
  logic [SW-1:0] respData;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;  // 125 MHz

  vgate_supervisor #(.SW(SW), .DEPTH(DEPTH), .PREROLL(PREROLL), .CW(CW), .HW(HW)) u_vgate_supervisor (
    .clk(clk), .rstN(rstN), .settleCycles(settleCycles), .hangFrames(hangFrames),
    .frameValid(frameValid), .frameSpeech(frameSpeech),
    .sampleValid(sampleValid), .sampleData(sampleData),
    .pwrEn(pwrEn), .recReset(recReset),
    .reqValid(reqValid), .respValid(respValid), .respData(respData), .overflow(overflow)
  );

  task automatic check(input string tag, input int actual, input int expected);
    compared++;
    if (actual != expected) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  task automatic pushSample(input int v);
    sampleValid = 1'b1;
    sampleData  = SW'(v);
    step();
    sampleValid = 1'b0;
  endtask

  task automatic frame(input logic sp);
    frameValid  = 1'b1;
    frameSpeech = sp;
    step();
    frameValid  = 1'b0;
    frameSpeech = 1'b0;
  endtask

  task automatic wake();
    frame(1'b1);
    for (int k = 0; k < 300 && recReset; k++) step();
  endtask

  task automatic readOne(output logic got, output int data);
    reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    got  = respValid;
    data = int'(respData);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic got;
    int   data;
    int   cnt;
    int   keep;

    // R1 reset state
    doReset();
    check("R1 pwrEn", int'(pwrEn), 0);
    check("R1 recReset", int'(recReset), 1);
    check("R1 respValid", int'(respValid), 0);
    check("R1 overflow", int'(overflow), 0);

    // power sequencing sweep: R2 R3 R4 R5
    for (int s = 0; s <= 4; s++) begin
      for (int h = 1; h <= 4; h++) begin
        doReset();
        settleCycles = CW'(s);
        hangFrames   = HW'(h);
        frame(1'b0);
        check("R2 silence keeps off", int'(pwrEn), 0);
        frame(1'b1);
        check("R2 pwrEn after speech", int'(pwrEn), 1);
        check("R2 reset held", int'(recReset), 1);
        cnt = 0;
        while (recReset && cnt < 50) begin
          step();
          cnt++;
          if (recReset) check("R5 power held while settling", int'(pwrEn), 1);
        end
        check("R3 release delay", cnt, s + 1);
        for (int q = 0; q < h - 1; q++) frame(1'b0);
        check("R4 short silence keeps run", int'(recReset), 0);
        frame(1'b1);
        for (int q = 0; q < h - 1; q++) frame(1'b0);
        check("R4 speech restarts count", int'(recReset), 0);
        frame(1'b0);
        check("R4 reset asserted", int'(recReset), 1);
        check("R5 power still on", int'(pwrEn), 1);
        step();
        check("R5 power removed after reset", int'(pwrEn), 0);
      end
    end

    // pre-roll sweep: R6 R7
    settleCycles = 8'd1;
    hangFrames   = 6'd2;
    for (int n = 0; n <= 20; n++) begin
      if (n > 12 && n != 20) continue;
      doReset();
      reqValid = 1'b1;
      step();
      reqValid = 1'b0;
      check("R7 no response while off", int'(respValid), 0);
      for (int k = 0; k < n; k++) pushSample(500 + k);
      wake();
      keep = (n < PREROLL) ? n : PREROLL;
      cnt = 0;
      for (int j = 0; j < 10; j++) begin
        readOne(got, data);
        if (!got) break;
        check("R7 arrival order", data, 500 + n - keep + j);
        cnt++;
      end
      check("R6 pre-roll kept", cnt, keep);
    end

    // streaming and overflow: R7 R8
    doReset();
    wake();
    for (int k = 0; k < 3; k++) pushSample(200 + k);
    for (int k = 0; k < 3; k++) begin
      readOne(got, data);
      check("R7 stream valid", int'(got), 1);
      check("R7 stream data", data, 200 + k);
    end
    readOne(got, data);
    check("R7 empty gives nothing", int'(got), 0);
    for (int k = 0; k < DEPTH; k++) pushSample(300 + k);
    check("R8 full but no loss", int'(overflow), 0);
    pushSample(300 + DEPTH);
    check("R8 overflow set", int'(overflow), 1);
    readOne(got, data);
    check("R8 oldest dropped", data, 301);
    step();
    check("R8 overflow sticky", int'(overflow), 1);
    frame(1'b0);
    frame(1'b0);
    step();
    check("R8 sticky while off", int'(overflow), 1);
    frame(1'b1);
    check("R8 cleared on wake", int'(overflow), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule